// File: doc/BRIEF.md
# Weekly and Daily Alarm Comparator with Interrupt

This block watches the time of day supplied by an external seconds/minutes/hours counter and raises an active-low interrupt when one of two programmable alarms comes due. The weekly alarm carries an hour, a minute and a seven-bit mask of the weekdays on which it may fire. The daily alarm carries only an hour and a minute and fires on any day. Each alarm has its own enable and its own sticky flag. The interrupt line is low while any enabled alarm has its flag set.

A match is taken only at the moment the time enters the alarm minute: the once-per-second tick at which the seconds value becomes 00 and hour, minute (and, for the weekly alarm, the weekday) agree with the alarm. An alarm that is switched on part-way through its own minute therefore waits for the next occurrence. Software loads alarm values through a small register port. To change an alarm safely it clears the enable, writes the new values, and then sets the enable again. A flag is cleared by writing 0 to its bit.

Top module: `rtc_dual_alarm`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is high. Addresses 6 and 7 always read 0.
- R2: Registers are at address 0 (weekly minute, 7 bits), 1 (weekly hour, 6 bits), 2 (weekday mask, 7 bits; bit d selects weekday code d, 0..6), 3 (daily minute, 7 bits), 4 (daily hour, 6 bits) and 5 (control). A write stores the low bits of the data, and a read returns them zero-extended to 8 bits.
- R3: Control bit 0 enables the weekly alarm. When it is set, a tick with seconds 00 and with minute and hour equal to the weekly values, on a weekday whose mask bit is 1, sets the weekly flag (control bit 4). `irq_n` is low in the cycle after that tick.
- R4: The weekly alarm does not fire when the mask bit for the current weekday is 0, or when the weekday code is 7.
- R5: Control bit 1 enables the daily alarm. A tick with seconds 00 and matching minute and hour sets the daily flag (control bit 5) on any weekday.
- R6: No flag is set when the tick is absent, or when seconds is not 00. Enabling an alarm inside its matching minute does not assert `irq_n` until the next entry into that minute.
- R7: An alarm whose enable is 0 does not set its flag on a match.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged, and flag bits cannot be set by software.
- R9: If a clearing write and a match of an enabled alarm fall in the same cycle, the flag ends up set.
- R10: `irq_n` is low exactly when (weekly flag and weekly enable) or (daily flag and daily enable). Clearing an enable releases the line and leaves the flag readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse: the time inputs have just advanced by one second |
| cur_sec | input | 7 | Current seconds, BCD 00..59 |
| cur_min | input | 7 | Current minutes, BCD 00..59 |
| cur_hour | input | 6 | Current hours, BCD 00..23 |
| cur_wday | input | 3 | Current weekday code, 0..6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
The assertions assume that `tick` lasts one cycle and that the time inputs already show the new second in the cycle where `tick` is high. They also assume that the time inputs are valid BCD and the weekday code stays in 0..6, except where a test feeds code 7 on purpose. The bench drives time only through one task that always pulses `tick` for one cycle together with the new time. Random times are drawn from a small set of legal hours, minutes and seconds near the alarm values, so matches, near misses and mid-minute ticks all occur often. Register writes are drawn from values that keep the control layout meaningful.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] AD_WK_MIN  = 3'd0;
  localparam logic [REG_AW-1:0] AD_WK_HOUR = 3'd1;
  localparam logic [REG_AW-1:0] AD_WK_DAYS = 3'd2;
  localparam logic [REG_AW-1:0] AD_DY_MIN  = 3'd3;
  localparam logic [REG_AW-1:0] AD_DY_HOUR = 3'd4;
  localparam logic [REG_AW-1:0] AD_CTRL    = 3'd5;

  localparam int CB_WK_EN   = 0;
  localparam int CB_DY_EN   = 1;
  localparam int CB_WK_FLAG = 4;
  localparam int CB_DY_FLAG = 5;

  // alarm set indices inside flag/enable vectors
  localparam int SET_WK = 0;
  localparam int SET_DY = 1;
  localparam int NSETS  = 2;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAYS   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [NSETS-1:0]  flag,
  output logic [MIN_W-1:0]  wk_min,
  output logic [HOUR_W-1:0] wk_hour,
  output logic [DAYS-1:0]   wk_days,
  output logic [MIN_W-1:0]  dy_min,
  output logic [HOUR_W-1:0] dy_hour,
  output logic [NSETS-1:0]  en,
  output logic [NSETS-1:0]  clr,
  output logic [REG_DW-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  logic ctrl_wr;
  assign ctrl_wr = wr && (addr == AD_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_min  <= '0;
      wk_hour <= '0;
      wk_days <= '0;
      dy_min  <= '0;
      dy_hour <= '0;
      en      <= '0;
    end else if (wr) begin
      case (addr)
        AD_WK_MIN:  wk_min  <= wdata[MIN_W-1:0];
        AD_WK_HOUR: wk_hour <= wdata[HOUR_W-1:0];
        AD_WK_DAYS: wk_days <= wdata[DAYS-1:0];
        AD_DY_MIN:  dy_min  <= wdata[MIN_W-1:0];
        AD_DY_HOUR: dy_hour <= wdata[HOUR_W-1:0];
        AD_CTRL: begin
          en[SET_WK] <= wdata[CB_WK_EN];
          en[SET_DY] <= wdata[CB_DY_EN];
        end
        default: ;
      endcase
    end
  end

  // a zero written to a flag position requests a clear; a one is ignored
  assign clr[SET_WK] = ctrl_wr && !wdata[CB_WK_FLAG];
  assign clr[SET_DY] = ctrl_wr && !wdata[CB_DY_FLAG];

  always_comb begin
    rdata = '0;
    case (addr)
      AD_WK_MIN:  rdata[MIN_W-1:0]  = wk_min;
      AD_WK_HOUR: rdata[HOUR_W-1:0] = wk_hour;
      AD_WK_DAYS: rdata[DAYS-1:0]   = wk_days;
      AD_DY_MIN:  rdata[MIN_W-1:0]  = dy_min;
      AD_DY_HOUR: rdata[HOUR_W-1:0] = dy_hour;
      AD_CTRL: begin
        rdata[CB_WK_EN]   = en[SET_WK];
        rdata[CB_DY_EN]   = en[SET_DY];
        rdata[CB_WK_FLAG] = flag[SET_WK];
        rdata[CB_DY_FLAG] = flag[SET_DY];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int SEC_W    = 7,
  parameter int MIN_W    = 7,
  parameter int HOUR_W   = 6,
  parameter int DAYS     = 7,
  parameter int WDAY_W   = 3,
  parameter bit USE_DAYS = 1'b1
) (
  input  logic              tick,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MIN_W-1:0]  al_min,
  input  logic [HOUR_W-1:0] al_hour,
  input  logic [DAYS-1:0]   al_days,
  output logic              hit
);
  // the tick that moves seconds to zero opens a new minute
  function automatic logic minute_opens(input logic tk, input logic [SEC_W-1:0] s);
    return tk && (s == '0);
  endfunction

  function automatic logic day_selected(input logic [DAYS-1:0] mask,
                                        input logic [WDAY_W-1:0] wd);
    logic sel;
    sel = 1'b0;
    for (int d = 0; d < DAYS; d++)
      if ((wd == WDAY_W'(d)) && mask[d]) sel = 1'b1;
    return sel;
  endfunction

  logic entry, hm_eq, day_ok;
  assign entry = minute_opens(tick, cur_sec);
  assign hm_eq = (cur_min == al_min) && (cur_hour == al_hour);

  generate
    if (USE_DAYS) begin : g_mask
      assign day_ok = day_selected(al_days, cur_wday);
    end else begin : g_any
      logic unused_day;
      assign unused_day = ^{al_days, cur_wday};
      assign day_ok = 1'b1;
    end
  endgenerate

  assign hit = entry && hm_eq && day_ok;
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic         irq_n
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               flag[i] <= 1'b0;
        else if (hit[i] && en[i]) flag[i] <= 1'b1;
        else if (clr[i])          flag[i] <= 1'b0;
      end
    end
  endgenerate

  assign irq_n = ~|(flag & en);
endmodule

// File: rtl/rtc_dual_alarm.sv
module rtc_dual_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAYS   = 7,
  localparam int WDAY_W = $clog2(DAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_n
);
  logic [MIN_W-1:0]  wk_min, dy_min;
  logic [HOUR_W-1:0] wk_hour, dy_hour;
  logic [DAYS-1:0]   wk_days;
  logic [NSETS-1:0]  en, clr, flag, hit;

  // named events for the checker
  logic wk_hit, dy_hit, wk_en, dy_en, wk_flag, dy_flag, wk_clr, dy_clr;

  rtc_alarm_regs #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAYS(DAYS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag(flag), .wk_min(wk_min), .wk_hour(wk_hour), .wk_days(wk_days),
    .dy_min(dy_min), .dy_hour(dy_hour), .en(en), .clr(clr), .rdata(reg_rdata)
  );

  rtc_alarm_cmp #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAYS(DAYS),
                  .WDAY_W(WDAY_W), .USE_DAYS(1'b1)) u_cmp_wk (
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .al_min(wk_min), .al_hour(wk_hour), .al_days(wk_days),
    .hit(wk_hit)
  );

  rtc_alarm_cmp #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAYS(DAYS),
                  .WDAY_W(WDAY_W), .USE_DAYS(1'b0)) u_cmp_dy (
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .al_min(dy_min), .al_hour(dy_hour), .al_days({DAYS{1'b1}}),
    .hit(dy_hit)
  );

  assign hit[SET_WK] = wk_hit;
  assign hit[SET_DY] = dy_hit;

  rtc_alarm_flags #(.N(NSETS)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit), .en(en), .clr(clr),
    .flag(flag), .irq_n(irq_n)
  );

  assign wk_en   = en[SET_WK];
  assign dy_en   = en[SET_DY];
  assign wk_flag = flag[SET_WK];
  assign dy_flag = flag[SET_DY];
  assign wk_clr  = clr[SET_WK];
  assign dy_clr  = clr[SET_DY];
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int SEC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [SEC_W-1:0] cur_sec,
  input logic             irq_n,
  input logic             wk_hit,
  input logic             dy_hit,
  input logic             wk_en,
  input logic             dy_en,
  input logic             wk_flag,
  input logic             dy_flag,
  input logic             wk_clr,
  input logic             dy_clr
);
  // R1
  reset_irq_high_chk: assert property (@(posedge clk) !rst_n |=> irq_n);

  // R3
  wk_match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_hit && wk_en) |=> wk_flag);

  // R5
  dy_match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dy_hit && dy_en) |=> dy_flag);

  // R6
  hit_only_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_hit || dy_hit) |-> (tick && (cur_sec == '0)));

  // R7
  wk_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wk_en && !wk_flag) |=> !wk_flag);

  // R7
  dy_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dy_en && !dy_flag) |=> !dy_flag);

  // R8
  wk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_clr && !(wk_hit && wk_en)) |=> !wk_flag);

  // R8
  dy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dy_clr && !(dy_hit && dy_en)) |=> !dy_flag);

  // R9
  wk_hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_clr && wk_hit && wk_en) |=> wk_flag);

  // R10
  irq_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wk_en && !dy_en) |-> irq_n);

  // R10
  irq_from_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_en && wk_flag) |-> !irq_n);
endmodule

bind rtc_dual_alarm rtc_alarm_chk #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .irq_n(irq_n),
  .wk_hit(wk_hit), .dy_hit(dy_hit), .wk_en(wk_en), .dy_en(dy_en),
  .wk_flag(wk_flag), .dy_flag(dy_flag), .wk_clr(wk_clr), .dy_clr(dy_clr)
);

// File: tb/sim_rtc_dual_alarm.sv
module sim_rtc_dual_alarm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side model of the programmable state
  logic [7:0] m_wk_min = 0, m_wk_hour = 0, m_wk_days = 0, m_dy_min = 0, m_dy_hour = 0;
  logic [1:0] m_en = 0, m_flag = 0;

  always #5 clk = ~clk;

  rtc_dual_alarm u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] ctrl_exp();
    return {2'b00, m_flag[1], m_flag[0], 2'b00, m_en[1], m_en[0]};
  endfunction

  function automatic logic [1:0] model_hits(input logic tk, input int h, input int m,
                                            input int s, input int wd);
    logic [1:0] r;
    logic entry;
    entry = tk && (s == 0);
    r[0] = entry && (to_bcd(m) == m_wk_min) && (to_bcd(h) == m_wk_hour)
           && (wd < 7) && m_wk_days[wd % 8];
    r[1] = entry && (to_bcd(m) == m_dy_min) && (to_bcd(h) == m_dy_hour);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: optional register write plus optional tick with a new time
  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic tk, input int h, input int m, input int s, input int wd);
    logic [1:0] hits;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; tick = tk;
    cur_hour = 6'(to_bcd(h)); cur_min = 7'(to_bcd(m)); cur_sec = 7'(to_bcd(s));
    cur_wday = 3'(wd);
    hits = model_hits(tk, h, m, s, wd);
    for (int i = 0; i < 2; i++) begin
      if (hits[i] && m_en[i]) m_flag[i] = 1'b1;
      else if (w && a == 3'd5 && !d[4 + i]) m_flag[i] = 1'b0;
    end
    if (w) begin
      case (a)
        3'd0: m_wk_min  = d & 8'h7F;
        3'd1: m_wk_hour = d & 8'h3F;
        3'd2: m_wk_days = d & 8'h7F;
        3'd3: m_dy_min  = d & 8'h7F;
        3'd4: m_dy_hour = d & 8'h3F;
        3'd5: m_en      = d[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 0, 0, 1, 0);
  endtask

  task automatic tk(input int h, input int m, input int s, input int wd);
    step(1'b0, 3'd0, 8'h00, 1'b1, h, m, s, wd);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_ctrl(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(3'd5, v);
    check(req, v, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register value", v, 8'h00);
    end
    check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

    // R2 field widths and readback
    wr(3'd0, 8'h59); rd(3'd0, v); check("R2 weekly minute", v, 8'h59);
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 weekly minute width", v, 8'h7F);
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R2 weekly hour width", v, 8'h3F);
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R2 weekday mask width", v, 8'h7F);
    wr(3'd3, 8'hA4); rd(3'd3, v); check("R2 daily minute", v, 8'h24);
    wr(3'd4, 8'hD2); rd(3'd4, v); check("R2 daily hour", v, 8'h12);
    wr(3'd6, 8'hFF); rd(3'd6, v); check("R1 unused address", v, 8'h00);
    // R8 software cannot set flags
    wr(3'd5, 8'hFF); chk_ctrl("R8 flag write 1 no effect", 8'h03);
    wr(3'd5, 8'h00);

    // alarm setup: weekly 07:30 on weekday 3, daily 08:15
    wr(3'd0, 8'h30); wr(3'd1, 8'h07); wr(3'd2, 8'h08);
    wr(3'd3, 8'h15); wr(3'd4, 8'h08); wr(3'd5, 8'h01);

    tk(7, 29, 59, 3);
    check("R3 before minute", {7'd0, irq_n}, 8'h01);
    tk(7, 30, 0, 3);
    check("R3 weekly fires", {7'd0, irq_n}, 8'h00);
    chk_ctrl("R3 weekly flag", 8'h11);
    wr(3'd5, 8'h11);
    check("R8 write 1 keeps irq", {7'd0, irq_n}, 8'h00);
    chk_ctrl("R8 write 1 keeps flag", 8'h11);
    wr(3'd5, 8'h01);
    check("R8 clear releases irq", {7'd0, irq_n}, 8'h01);
    chk_ctrl("R8 clear flag", 8'h01);

    tk(7, 30, 5, 3);
    check("R6 mid-minute tick", {7'd0, irq_n}, 8'h01);
    step(1'b0, 3'd0, 8'h00, 1'b0, 7, 30, 0, 3);
    check("R6 no tick", {7'd0, irq_n}, 8'h01);
    tk(7, 30, 0, 4);
    check("R4 mask bit clear", {7'd0, irq_n}, 8'h01);
    tk(7, 30, 0, 7);
    check("R4 weekday code 7", {7'd0, irq_n}, 8'h01);
    tk(7, 31, 0, 3);
    check("R3 wrong minute", {7'd0, irq_n}, 8'h01);

    tk(8, 15, 0, 2);
    chk_ctrl("R7 disabled daily no flag", 8'h01);

    // enable during matching minute
    step(1'b1, 3'd5, 8'h03, 1'b1, 8, 15, 20, 2);
    check("R6 enable inside minute", {7'd0, irq_n}, 8'h01);
    tk(8, 15, 21, 2);
    check("R6 later tick same minute", {7'd0, irq_n}, 8'h01);
    tk(8, 15, 0, 6);
    check("R5 daily fires", {7'd0, irq_n}, 8'h00);
    chk_ctrl("R5 daily flag", 8'h23);

    tk(7, 30, 0, 3);
    chk_ctrl("R10 both flags", 8'h33);
    wr(3'd5, 8'h32);
    check("R10 daily still holds irq", {7'd0, irq_n}, 8'h00);
    wr(3'd5, 8'h30);
    check("R10 enables off release irq", {7'd0, irq_n}, 8'h01);
    chk_ctrl("R10 flags retained", 8'h30);
    wr(3'd5, 8'h03);
    chk_ctrl("R8 clear both", 8'h03);

    tk(7, 30, 0, 3);
    chk_ctrl("R9 weekly set again", 8'h13);
    step(1'b1, 3'd5, 8'h03, 1'b1, 7, 30, 0, 3);
    chk_ctrl("R9 match beats clear", 8'h13);
    check("R9 irq stays low", {7'd0, irq_n}, 8'h00);
    wr(3'd5, 8'h03);
    check("R8 final clear", {7'd0, irq_n}, 8'h01);

    // constrained random phase checked against the bench model
    for (int it = 0; it < 600; it++) begin
      int h, m, s, wd, sel;
      logic w, t;
      logic [2:0] a;
      logic [7:0] d;
      h  = ($urandom % 2 == 0) ? 7 : 8;
      sel = $urandom % 3;
      m  = (sel == 0) ? 30 : (sel == 1) ? 15 : 31;
      s  = ($urandom % 3 == 0) ? 37 : 0;
      wd = $urandom % 7;
      t  = ($urandom % 5) != 0;
      w  = ($urandom % 4) == 0;
      a  = 3'd5;
      d  = 8'($urandom) & 8'h33;
      if (w && ($urandom % 6 == 0)) begin
        a = 3'd2;
        d = 8'($urandom);
      end
      step(w, a, d, t, h, m, s, wd);
      check("R10 random irq", {7'd0, irq_n},
            {7'd0, ~|(m_flag & m_en)});
      if (it % 8 == 0) chk_ctrl("R3 R5 random control", ctrl_exp());
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule